// File: doc/BRIEF.md
# Dual-Enable Byte-Lane SRAM Array

This block is a synthesizable, depth-parameterised model of an asynchronous static RAM with a 16-bit data path. It is meant to stand in for an external memory inside a larger simulation or emulation fabric. A fast sampling clock registers the memory's control pins, and the block derives the access mode from them. The pins are two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable for each byte lane. Real tristate drivers are replaced by a per-lane drive flag next to a plain output bus.

Writes follow the asynchronous convention. A write lasts for as long as the selecting conditions overlap. It is committed to the array only when the model sees the cycle in which that overlap has ended. The data, address and lanes stored are those present in the last cycle of the overlap. A static strap turns the block into a byte-wide memory of twice the depth. In that mode the top data pin is the most significant address bit.

Top module: `byte_lane_sram`

## Requirements
- R1: When `cs_lo_n` is 1 or `cs_hi` is 0, the block is in standby. `standby` is 1, both drive flags are 0, and a write strobe in that state changes no stored byte.
- R2: In 16-bit mode (`wide_mode`=1), `lane_lo_n`=1 together with `lane_hi_n`=1 is also standby, even with both chip selects active. A write strobe in that state stores nothing.
- R3: The block is selected when `cs_lo_n`=0 and `cs_hi`=1. When selected with `we_n`=0 it writes, whatever the value of `oe_n`. `dq_in[7:0]` goes to the low lane when `lane_lo_n`=0, and `dq_in[15:8]` goes to the high lane when `lane_hi_n`=0. A lane whose enable is 1 keeps its old value.
- R4: When selected with `we_n`=1 and `oe_n`=0, the block reads. `dq_oe_lo` follows `!lane_lo_n` and `dq_oe_hi` follows `!lane_hi_n`. A driven lane carries the stored byte of `addr` on `dq_out` (low lane on bits 7:0, high lane on bits 15:8), and an undriven lane of `dq_out` reads 0.
- R5: When selected with `we_n`=1 and `oe_n`=1, the outputs are disabled. Both drive flags are 0 and `dq_out` is 0, but `standby` is 0.
- R6: While a write is in progress neither drive flag is set, even with `oe_n`=0.
- R7: A write is committed once, after the overlap of `we_n`=0, chip selected and at least one enabled lane has ended. Any one of those signals going inactive ends it. The stored data, address and lanes are those sampled in the last cycle of the overlap.
- R8: With `wide_mode`=0 the block is byte wide. The byte address is {`dq_in[15]`, `addr`}: `dq_in[15]`=0 selects the low lane of word `addr` and `dq_in[15]`=1 selects its high lane. The block reads and writes on bits 7:0 only, and `dq_oe_hi` stays 0. `lane_lo_n`, `lane_hi_n` and `dq_in[14:8]` have no effect.
- R9: The outputs follow the pins sampled at the previous rising clock edge. A committed write is visible to a read issued in the cycle after the overlap ends.
- R10: During reset and right after it, `standby` is 1 and both drive flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| lane_lo_n | input | 1 | Active-low enable of bits 7:0 |
| lane_hi_n | input | 1 | Active-low enable of bits 15:8 |
| wide_mode | input | 1 | Strap: 1 = 16-bit words, 0 = bytes at double depth |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data into the memory; bit 15 is also the byte-address MSB in byte mode |
| dq_out | output | 16 | Data out of the memory; undriven lanes are 0 |
| dq_oe_lo | output | 1 | Bits 7:0 are being driven |
| dq_oe_hi | output | 1 | Bits 15:8 are being driven |
| standby | output | 1 | Deselect / low-power decode |

## Verification
The assertions check the following on every cycle: a write or standby never drives a lane, an undriven upper lane reads zero, the output-disabled mode stays active with no drive, byte mode never drives the upper lane, and a write commits at most once per overlap. Which bytes end up stored, the data captured at the terminating edge for each of the four ways of ending a write, the byte-address mapping and the one-cycle latency can only be shown by the bench's write-then-read sweeps. The bench also sweeps all 64 combinations of the control pins and compares the mode decode against a formula.

// File: rtl/bls_pkg.sv
`timescale 1ns/1ps
package bls_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BUS_W  = LANE_W * LANES;

  typedef enum logic [1:0] {
    ACC_STANDBY = 2'd0,
    ACC_READ    = 2'd1,
    ACC_QUIET   = 2'd2,
    ACC_WRITE   = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic lo_n;
    logic hi_n;
    logic wide;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1,
                                     rd_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1,
                                     wide: 1'b1};

endpackage

// File: rtl/bls_pin_sampler.sv
`timescale 1ns/1ps
module bls_pin_sampler
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  pin_set_t          pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  data_i,
  output pin_set_t          pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BUS_W-1:0]  data_q,
  output pin_set_t          pins_qq,
  output logic [ADDR_W-1:0] addr_qq,
  output logic [BUS_W-1:0]  data_qq
);

  pin_set_t          pins_d, pins_dd;
  logic [ADDR_W-1:0] addr_d, addr_dd;
  logic [BUS_W-1:0]  data_d, data_dd;

  // next state: newest sample and one-cycle-older sample
  always_comb begin
    pins_d  = pins_q;
    addr_d  = addr_q;
    data_d  = data_q;
    pins_dd = pins_qq;
    addr_dd = addr_qq;
    data_dd = data_qq;
    if (cap_en) begin
      pins_d  = pins_i;
      addr_d  = addr_i;
      data_d  = data_i;
      pins_dd = pins_q;
      addr_dd = addr_q;
      data_dd = data_q;
    end
  end

  // control samples carry reset so the block starts deselected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= PINS_IDLE;
      pins_qq <= PINS_IDLE;
    end else begin
      pins_q  <= pins_d;
      pins_qq <= pins_dd;
    end
  end

  // address and data samples need no reset
  always_ff @(posedge clk) begin
    addr_q  <= addr_d;
    data_q  <= data_d;
    addr_qq <= addr_dd;
    data_qq <= data_dd;
  end

endmodule

// File: rtl/bls_mode_decode.sv
`timescale 1ns/1ps
module bls_mode_decode
  import bls_pkg::*;
(
  input  pin_set_t  pins,
  input  logic      byte_msb,
  output acc_mode_e mode,
  output logic      standby,
  output logic      wr_lo,
  output logic      wr_hi,
  output logic      rd_lo,
  output logic      rd_hi
);

  logic selected;
  logic lanes_off;
  logic lane_lo;
  logic lane_hi;

  always_comb begin
    selected  = !pins.sel_n && pins.sel;
    lanes_off = pins.wide && pins.lo_n && pins.hi_n;
    standby   = !selected || lanes_off;

    if (standby)         mode = ACC_STANDBY;
    else if (!pins.wr_n) mode = ACC_WRITE;
    else if (!pins.rd_n) mode = ACC_READ;
    else                 mode = ACC_QUIET;

    // byte mode: lane chosen by the extra address bit, lane pins ignored
    lane_lo = pins.wide ? !pins.lo_n : !byte_msb;
    lane_hi = pins.wide ? !pins.hi_n :  byte_msb;

    wr_lo = (mode == ACC_WRITE) && lane_lo;
    wr_hi = (mode == ACC_WRITE) && lane_hi;
    rd_lo = (mode == ACC_READ) && (pins.wide ? !pins.lo_n : 1'b1);
    rd_hi = (mode == ACC_READ) && pins.wide && !pins.hi_n;
  end

endmodule

// File: rtl/bls_lane_store.sv
`timescale 1ns/1ps
module bls_lane_store #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WIDTH  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/byte_lane_sram.sv
`timescale 1ns/1ps
module byte_lane_sram
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              wide_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi,
  output logic              standby
);

  localparam int unsigned MSB = BUS_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pin_set_t          pins_in;
  pin_set_t          pins_q, pins_qq;
  logic [ADDR_W-1:0] addr_q, addr_qq;
  logic [BUS_W-1:0]  data_q, data_qq;

  assign pins_in = '{sel_n: cs_lo_n, sel: cs_hi, wr_n: we_n, rd_n: oe_n,
                     lo_n: lane_lo_n, hi_n: lane_hi_n, wide: wide_mode};

  bls_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_en  (1'b1),
    .pins_i  (pins_in),
    .addr_i  (addr),
    .data_i  (dq_in),
    .pins_q  (pins_q),
    .addr_q  (addr_q),
    .data_q  (data_q),
    .pins_qq (pins_qq),
    .addr_qq (addr_qq),
    .data_qq (data_qq)
  );

  acc_mode_e now_mode, old_mode;
  logic      now_stby, old_stby;
  logic      now_wr_lo, now_wr_hi, now_rd_lo, now_rd_hi;
  logic      old_wr_lo, old_wr_hi, old_rd_lo, old_rd_hi;

  bls_mode_decode u_dec_now (
    .pins     (pins_q),
    .byte_msb (data_q[MSB]),
    .mode     (now_mode),
    .standby  (now_stby),
    .wr_lo    (now_wr_lo),
    .wr_hi    (now_wr_hi),
    .rd_lo    (now_rd_lo),
    .rd_hi    (now_rd_hi)
  );

  bls_mode_decode u_dec_old (
    .pins     (pins_qq),
    .byte_msb (data_qq[MSB]),
    .mode     (old_mode),
    .standby  (old_stby),
    .wr_lo    (old_wr_lo),
    .wr_hi    (old_wr_hi),
    .rd_lo    (old_rd_lo),
    .rd_hi    (old_rd_hi)
  );

  // commit on the first sample after the write overlap is gone
  logic commit;
  assign commit = (old_mode == ACC_WRITE) && (now_mode != ACC_WRITE);

  logic [LANES-1:0]  lane_we;
  logic [LANE_W-1:0] lane_wd [LANES];
  logic [LANE_W-1:0] lane_rd [LANES];

  assign lane_we = {commit && old_wr_hi, commit && old_wr_lo};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      // byte mode writes the low data byte into whichever lane is chosen
      always_comb begin
        if (pins_qq.wide) lane_wd[g] = data_qq[g*LANE_W +: LANE_W];
        else              lane_wd[g] = data_qq[LANE_W-1:0];
      end

      bls_lane_store #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_store (
        .clk     (clk),
        .wr_en   (lane_we[g]),
        .wr_addr (addr_qq),
        .wr_data (lane_wd[g]),
        .rd_addr (addr_q),
        .rd_data (lane_rd[g])
      );
    end
  endgenerate

  logic [LANE_W-1:0] low_byte;

  always_comb begin
    if (!pins_q.wide && data_q[MSB]) low_byte = lane_rd[1];
    else                             low_byte = lane_rd[0];
    dq_out   = {now_rd_hi ? lane_rd[1] : '0, now_rd_lo ? low_byte : '0};
    dq_oe_lo = now_rd_lo;
    dq_oe_hi = now_rd_hi;
    standby  = now_stby;
  end

  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (now_mode == ACC_WRITE) |-> !(dq_oe_lo || dq_oe_hi));

  // R1
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    standby |-> (!dq_oe_lo && !dq_oe_hi && dq_out == '0));

  // R5
  quiet_active_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (now_mode == ACC_QUIET) |-> (!standby && !dq_oe_lo && !dq_oe_hi));

  // R4
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dq_oe_hi |-> (dq_out[15:8] == '0));

  // R8
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pins_q.wide |-> !dq_oe_hi);

  // R7
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit |=> !commit);

endmodule

// File: tb/sim_byte_lane_sram.sv
`timescale 1ns/1ps
module sim_byte_lane_sram;

  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_lo_n, cs_hi, we_n, oe_n, ln_lo_n, ln_hi_n, wide;
  logic [AW-1:0] addr;
  logic [15:0]   din;
  logic [15:0]   dout;
  logic          oe_lo, oe_hi, stby;

  int checks = 0;
  int errors = 0;

  logic [7:0] lo_ref [DEPTH];
  logic [7:0] hi_ref [DEPTH];

  always #10 clk = ~clk;

  byte_lane_sram #(.ADDR_W(AW)) u0 (
    .clk (clk), .rst_n (rst_n), .cs_lo_n (cs_lo_n), .cs_hi (cs_hi),
    .we_n (we_n), .oe_n (oe_n), .lane_lo_n (ln_lo_n), .lane_hi_n (ln_hi_n),
    .wide_mode (wide), .addr (addr), .dq_in (din), .dq_out (dout),
    .dq_oe_lo (oe_lo), .dq_oe_hi (oe_hi), .standby (stby)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic a, input logic b, input logic w, input logic o,
                     input logic l, input logic h, input logic md,
                     input logic [AW-1:0] ad, input logic [15:0] dd);
    cs_lo_n = a; cs_hi = b; we_n = w; oe_n = o;
    ln_lo_n = l; ln_hi_n = h; wide = md; addr = ad; din = dd;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int a, input int salt);
    return 16'(a * 16'h01F3 + salt * 16'h00A5 + 16'h3C1);
  endfunction

  // word write in 16-bit mode, ended by one of four signals
  task automatic wr_word(input int ad, input logic [15:0] dd,
                         input logic l, input logic h, input int term);
    put(0, 1, 0, 1, l, h, 1, AW'(ad), dd);
    tick();
    case (term % 4)
      0: put(0, 1, 1, 1, l, h, 1, AW'(ad), dd);
      1: put(1, 1, 0, 1, l, h, 1, AW'(ad), dd);
      2: put(0, 0, 0, 1, l, h, 1, AW'(ad), dd);
      default: put(0, 1, 0, 1, 1, 1, 1, AW'(ad), dd);
    endcase
    tick();
    if (!l) lo_ref[ad] = dd[7:0];
    if (!h) hi_ref[ad] = dd[15:8];
  endtask

  task automatic rd_word(input int ad, input logic l, input logic h, input string tag);
    put(0, 1, 1, 0, l, h, 1, AW'(ad), 16'h0);
    tick();
    chk({tag, " data"}, 32'(dout), 32'({h ? 8'h00 : hi_ref[ad], l ? 8'h00 : lo_ref[ad]}));
    chk({tag, " oe"}, 32'({oe_hi, oe_lo}), 32'({!h, !l}));
    chk({tag, " standby"}, 32'(stby), 32'(h && l));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    put(1, 0, 1, 1, 1, 1, 1, '0, 16'h0);
    repeat (3) tick();
    // R10: reset state
    chk("R10 standby in reset", 32'(stby), 32'd1);
    chk("R10 oe in reset", 32'({oe_hi, oe_lo}), 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R10 standby after reset", 32'(stby), 32'd1);
    chk("R10 oe after reset", 32'({oe_hi, oe_lo}), 32'd0);

    // R3 R7: full-word writes, every way of ending a write, then readback
    for (int a = 0; a < DEPTH; a++) wr_word(a, pat(a, 1), 0, 0, a);
    for (int a = 0; a < DEPTH; a++) rd_word(a, 0, 0, "R3 R7 full word");

    // R3: lane-selective writes leave the other lane alone
    for (int a = 0; a < DEPTH; a++) wr_word(a, pat(a, 2), 0, 1, a + 1);
    for (int a = 0; a < DEPTH; a += 2) wr_word(a, pat(a, 3), 1, 0, a + 2);
    for (int a = 0; a < DEPTH; a++) rd_word(a, 0, 0, "R3 lane write");

    // R4: single-lane reads
    for (int a = 0; a < DEPTH; a += 3) begin
      rd_word(a, 0, 1, "R4 low lane read");
      rd_word(a, 1, 0, "R4 high lane read");
    end

    // R1 R2 R4 R5 R6: all 64 pin combinations, data equals stored content
    for (int c = 0; c < 64; c++) begin
      logic a, b, w, o, l, h, sb, wr, rd;
      int ad;
      {a, b, w, o, l, h} = 6'(c);
      ad = c % DEPTH;
      put(a, b, w, o, l, h, 1, AW'(ad), {hi_ref[ad], lo_ref[ad]});
      tick();
      sb = a || !b || (l && h);
      wr = !sb && !w;
      rd = !sb && w && !o;
      chk("R1 R2 sweep standby", 32'(stby), 32'(sb));
      chk("R4 R5 R6 sweep oe", 32'({oe_hi, oe_lo}), 32'({rd && !h, rd && !l}));
      chk("R4 R5 sweep data", 32'(dout),
          32'({(rd && !h) ? hi_ref[ad] : 8'h00, (rd && !l) ? lo_ref[ad] : 8'h00}));
      if (wr) chk("R6 no drive in write", 32'({oe_hi, oe_lo}), 32'd0);
    end

    // R3 R6: write with oe_n low, no drive during it, stored afterwards
    put(0, 1, 0, 0, 0, 0, 1, AW'(5), 16'hBEEF);
    tick();
    chk("R6 write with oe low", 32'({oe_hi, oe_lo}), 32'd0);
    chk("R3 write is active", 32'(stby), 32'd0);
    put(0, 1, 1, 1, 0, 0, 1, AW'(5), 16'hBEEF);
    tick();
    lo_ref[5] = 8'hEF; hi_ref[5] = 8'hBE;
    rd_word(5, 0, 0, "R3 write ignoring oe");

    // R1 R2: strobes while deselected store nothing
    put(1, 1, 0, 1, 0, 0, 1, AW'(6), 16'h1111); tick();
    put(0, 0, 0, 1, 0, 0, 1, AW'(6), 16'h2222); tick();
    put(0, 1, 0, 1, 1, 1, 1, AW'(6), 16'h3333); tick();
    put(1, 0, 1, 1, 1, 1, 1, AW'(6), 16'h0); tick();
    rd_word(6, 0, 0, "R1 R2 deselected write ignored");

    // R7: data changing during a long write; the last cycle's value is kept
    put(0, 1, 0, 1, 0, 0, 1, AW'(7), 16'hAAAA); tick();
    put(0, 1, 0, 1, 0, 0, 1, AW'(7), 16'h5555); tick();
    put(0, 1, 0, 1, 0, 0, 1, AW'(7), 16'hC3A5); tick();
    put(0, 1, 1, 1, 0, 0, 1, AW'(7), 16'h0F0F); tick();
    lo_ref[7] = 8'hA5; hi_ref[7] = 8'hC3;
    rd_word(7, 0, 0, "R7 last overlap data");

    // R9: the outputs change only after the next sampling edge
    put(1, 0, 1, 1, 1, 1, 1, '0, 16'h0); tick();
    put(0, 1, 1, 0, 0, 0, 1, AW'(7), 16'h0);
    #1;
    chk("R9 before edge standby", 32'(stby), 32'd1);
    tick();
    chk("R9 after edge data", 32'(dout), 32'hC3A5);

    // R8: byte mode, both lane enables high and junk on dq_in[14:8]
    for (int b = 0; b < 2 * DEPTH; b++) begin
      logic [7:0] bp;
      bp = 8'(b * 37 + 11);
      put(0, 1, 0, 1, 1, 1, 0, AW'(b % DEPTH), {1'(b / DEPTH), 7'h55, bp});
      tick();
      put(0, 1, 1, 1, 1, 1, 0, AW'(b % DEPTH), {1'(b / DEPTH), 7'h2A, bp});
      tick();
      if (b / DEPTH == 1) hi_ref[b % DEPTH] = bp;
      else                lo_ref[b % DEPTH] = bp;
    end
    for (int b = 0; b < 2 * DEPTH; b++) begin
      put(0, 1, 1, 0, 1, 1, 0, AW'(b % DEPTH), {1'(b / DEPTH), 7'h7F, 8'h00});
      tick();
      chk("R8 byte read data", 32'(dout),
          32'({8'h00, (b / DEPTH == 1) ? hi_ref[b % DEPTH] : lo_ref[b % DEPTH]}));
      chk("R8 byte read oe", 32'({oe_hi, oe_lo}), 32'b01);
      chk("R8 lane pins ignored", 32'(stby), 32'd0);
    end
    put(0, 0, 1, 0, 0, 0, 0, '0, 16'h0); tick();
    chk("R8 R1 byte mode deselect", 32'(stby), 32'd1);
    for (int a = 0; a < DEPTH; a++) rd_word(a, 0, 0, "R8 byte map in word view");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule